// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt requests from seven external pins and a parameterized number of internal sources. It keeps the edge-captured ones latched, drops those that are masked, unavailable or already being serviced, and offers the CPU one request at a time: the winner of a priority contest, with an 8-bit vector type. A CPU acknowledge moves the winner into the in-service register and clears the global enable flag. Software sets the flag again to allow nesting. An end-of-interrupt command retires the in-service entry with the highest priority.

Pins 0 to 4 can each be set to edge or level sensing. Pins 5 and 6 always sense edges, and they yield to DMA when their DMA channel takes requests from outside. Sources 0 and 1 can each run in cascade mode toward an external slave controller. In that mode the neighbouring pin (2 or 3) becomes an acknowledge strobe. Those two sources can also run fully nested, which lets them re-interrupt their own service routine. A slave-mode setting withdraws pins 4 to 6.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is held and after it is released, `irq` is 0, `ien` is 0, `isr` is all zeros and `inta_n` is 2'b11.
- R2: Among the eligible sources, the one with the smallest 3-bit priority value wins, and a tie goes to the lower index. `irq_type` equals `VEC_BASE` (default 32) plus the winner's index. Pins are indices 0 to 6 and internal sources follow from index 7.
- R3: A pin among 0 to 4 with its `cfg_level` bit at 1 requests for as long as it is high. With the bit at 0, a rising edge latches a request that stays pending after the pin falls, until that source is acknowledged.
- R4: Pins 5 and 6 sense edges only, so a pin held high does not request again after acknowledge. A `dma_ext_sync` bit at 1 (bit 0 for pin 5, bit 1 for pin 6) makes that pin ignored.
- R5: With `cfg_cascade[0]` at 1, pin 2 is ignored and `inta_n[0]` is driven low during the acknowledge of source 0. `cfg_cascade[1]` does the same for pin 3, `inta_n[1]` and source 1. At most one acknowledge strobe is low at any time.
- R6: While a source's `isr` bit is set, that source is not presented. The exception is source 0 or 1 with its `cfg_sfnm` bit at 1, which may be presented again. Acknowledge sets the winner's `isr` bit.
- R7: `irq` is asserted only while `ien` is 1. An acknowledge taken while `irq` is high clears `ien`, and a pulse on `ien_set` sets it.
- R8: While any `isr` bit is set, only sources whose priority value is less than or equal to that of the highest-priority in-service source are presented.
- R9: `eoi` clears exactly one `isr` bit: the one with the smallest priority value, with a tie going to the lower index.
- R10: With `cfg_slave` at 1, pins 4, 6 and 5 are ignored. Edges seen during that time are not kept.
- R11: A source whose `cfg_mask` bit is 1 is not presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req | input | 7 | External request pins 0..6 |
| int_req | input | N_INT | Internal level requests (timers, DMA, serial, watchdog) |
| cfg_level | input | 5 | Level (1) or edge (0) sensing for pins 0..4 |
| cfg_mask | input | N_SRC | Per-source mask, 1 blocks |
| cfg_prio | input | N_SRC*PW | Packed priority values, source i at bits i*PW |
| cfg_cascade | input | 2 | Cascade mode for sources 0 and 1 |
| cfg_sfnm | input | 2 | Fully nested mode for sources 0 and 1 |
| cfg_slave | input | 1 | Slave mode, withdraws pins 4..6 |
| dma_ext_sync | input | 2 | DMA channel 0/1 owns pin 5/6 |
| ien_set | input | 1 | Software sets the global enable |
| ack | input | 1 | CPU interrupt acknowledge |
| eoi | input | 1 | End-of-interrupt command |
| irq | output | 1 | Request to the CPU |
| irq_type | output | 8 | Vector type of the presented request |
| inta_n | output | 2 | Active-low cascade acknowledge strobes |
| ien | output | 1 | Global interrupt enable flag |
| isr | output | N_SRC | In-service register |

## Verification
The hardest state to reach is a nest of two in-service sources. It has to coexist with a lower-priority request that is blocked by threshold and with a blocked self-request from a level pin that stays high. The bench builds it on purpose: it acknowledges a level source, re-enables, raises a weaker pin and then a stronger internal source, and acknowledges again. Two end-of-interrupt commands then peel the nest back in priority order. Fully nested re-entry and the edge-only pins need an acknowledge, a re-enable and an end-of-interrupt while the pin is still high, so that a missing or spurious re-request shows on `irq`.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int EXT_N  = 7;   // external request pins
   localparam int LVL_N  = 5;   // pins able to sense levels
   localparam int CASC_N = 2;   // sources with cascade / fully nested options
endpackage

// File: rtl/pic_src_stage.sv
module pic_src_stage #(
   parameter bit EDGE_ONLY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic level_mode,
   input  logic avail,
   input  logic clr,
   output logic req
);
   logic prev_q, pend_q, lvl;

   generate
      if (EDGE_ONLY) begin : g_edge
         assign lvl = 1'b0;
      end else begin : g_sel
         assign lvl = level_mode;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= pin;
         pend_q <= (pend_q & ~clr) | (pin & ~prev_q & avail & ~lvl);
      end
   end

   assign req = avail & (lvl ? pin : pend_q);

   AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(pin)) else $error("edge latch without rise"); // R3
endmodule

// File: rtl/pic_pick.sv
module pic_pick #(
   parameter int N  = 11,
   parameter int PW = 3,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]    valid,
   input  logic [N*PW-1:0] prio,
   output logic            any,
   output logic [IW-1:0]   idx,
   output logic [PW-1:0]   best
);
   always_comb begin
      any  = 1'b0;
      idx  = '0;
      best = '1;
      for (int i = 0; i < N; i++) begin
         if (valid[i] && (!any || prio[i*PW +: PW] < best)) begin
            any  = 1'b1;
            idx  = IW'(i);
            best = prio[i*PW +: PW];
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pic_pkg::*;
#(
   parameter int         N_INT    = 4,
   parameter int         PW       = 3,
   parameter logic [7:0] VEC_BASE = 8'd32,
   localparam int        N_SRC    = EXT_N + N_INT,
   localparam int        IW       = $clog2(N_SRC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [EXT_N-1:0]    ext_req,
   input  logic [N_INT-1:0]    int_req,
   input  logic [LVL_N-1:0]    cfg_level,
   input  logic [N_SRC-1:0]    cfg_mask,
   input  logic [N_SRC*PW-1:0] cfg_prio,
   input  logic [CASC_N-1:0]   cfg_cascade,
   input  logic [CASC_N-1:0]   cfg_sfnm,
   input  logic                cfg_slave,
   input  logic [1:0]          dma_ext_sync,
   input  logic                ien_set,
   input  logic                ack,
   input  logic                eoi,
   output logic                irq,
   output logic [7:0]          irq_type,
   output logic [CASC_N-1:0]   inta_n,
   output logic                ien,
   output logic [N_SRC-1:0]    isr
);
   generate
      if (N_INT < 1) begin : g_bad_int
         $error("N_INT must be at least 1");
      end
      if (PW < 1 || PW > 8) begin : g_bad_pw
         $error("PW out of range");
      end
      if (int'(VEC_BASE) + N_SRC > 256) begin : g_bad_vec
         $error("vector types overflow 8 bits");
      end
   endgenerate

   logic [N_SRC-1:0] req, elig, isr_q, isr_n, sfnm_vec;
   logic [EXT_N-1:0] ext_avail;
   logic [EXT_N-1:0] lvl_pad;
   logic             ien_q, win_any, isr_any, ack_take;
   logic [IW-1:0]    win_idx, isr_idx;
   logic [PW-1:0]    win_best, isr_best;

   // pin availability: cascade takes pins 2/3, slave takes 4..6, DMA takes 5/6
   assign ext_avail[0] = 1'b1;
   assign ext_avail[1] = 1'b1;
   assign ext_avail[2] = ~cfg_cascade[0];
   assign ext_avail[3] = ~cfg_cascade[1];
   assign ext_avail[4] = ~cfg_slave;
   assign ext_avail[5] = ~cfg_slave & ~dma_ext_sync[0];
   assign ext_avail[6] = ~cfg_slave & ~dma_ext_sync[1];
   assign lvl_pad      = {{(EXT_N-LVL_N){1'b0}}, cfg_level};
   assign sfnm_vec     = {{(N_SRC-CASC_N){1'b0}}, cfg_sfnm};

   generate
      for (genvar g = 0; g < EXT_N; g++) begin : g_ext
         pic_src_stage #(.EDGE_ONLY(g >= LVL_N)) u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (ext_req[g]),
            .level_mode (lvl_pad[g]),
            .avail      (ext_avail[g]),
            .clr        (ack_take && (win_idx == IW'(g))),
            .req        (req[g])
         );
      end
      for (genvar j = 0; j < N_INT; j++) begin : g_int
         assign req[EXT_N + j] = int_req[j];
      end
   endgenerate

   // in-service arbiter gives the nesting threshold and the EOI target
   pic_pick #(.N(N_SRC), .PW(PW)) u_isr_pick (
      .valid (isr_q),
      .prio  (cfg_prio),
      .any   (isr_any),
      .idx   (isr_idx),
      .best  (isr_best)
   );

   always_comb begin
      for (int i = 0; i < N_SRC; i++) begin
         elig[i] = req[i] & ~cfg_mask[i]
                 & (~isr_q[i] | sfnm_vec[i])
                 & (~isr_any | (cfg_prio[i*PW +: PW] <= isr_best));
      end
   end

   pic_pick #(.N(N_SRC), .PW(PW)) u_req_pick (
      .valid (elig),
      .prio  (cfg_prio),
      .any   (win_any),
      .idx   (win_idx),
      .best  (win_best)
   );

   assign irq      = ien_q & win_any;
   assign ack_take = ack & irq;
   assign irq_type = VEC_BASE + 8'(win_idx);

   generate
      for (genvar k = 0; k < CASC_N; k++) begin : g_inta
         assign inta_n[k] = ~(cfg_cascade[k] & ack_take & (win_idx == IW'(k)));
      end
   endgenerate

   always_comb begin
      isr_n = isr_q;
      if (eoi && isr_any) isr_n[isr_idx] = 1'b0;
      if (ack_take)       isr_n[win_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q <= '0;
         ien_q <= 1'b0;
      end else begin
         isr_q <= isr_n;
         if (ack_take)     ien_q <= 1'b0;
         else if (ien_set) ien_q <= 1'b1;
      end
   end

   assign isr = isr_q;
   assign ien = ien_q;

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ien) else $error("irq without enable"); // R7
   AST_ACK_DROPS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take |=> !ien) else $error("enable survived ack"); // R7
   AST_ACK_MARKS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take |=> isr_q[$past(win_idx)]) else $error("in-service not set"); // R6
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~inta_n)) else $error("two strobes low"); // R5
   AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && isr_any && !ack_take) |=> $countones(isr_q) == $countones($past(isr_q)) - 1)
      else $error("eoi cleared wrong count"); // R9
   AST_NEST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && isr_any) |-> win_best <= isr_best) else $error("weaker source nested"); // R8
   AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_slave |-> !(irq && win_idx >= IW'(4) && win_idx <= IW'(6)))
      else $error("withdrawn pin presented"); // R10
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
   localparam int N_INT = 4;
   localparam int PW    = 3;
   localparam int N_SRC = 7 + N_INT;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [6:0]          ext_req = '0;
   logic [N_INT-1:0]    int_req = '0;
   logic [4:0]          cfg_level = 5'b11111;
   logic [N_SRC-1:0]    cfg_mask = '0;
   logic [N_SRC*PW-1:0] cfg_prio;
   logic [1:0]          cfg_cascade = '0, cfg_sfnm = '0, dma_ext_sync = '0;
   logic                cfg_slave = 1'b0, ien_set = 1'b0, ack = 1'b0, eoi = 1'b0;
   logic                irq, ien;
   logic [7:0]          irq_type;
   logic [1:0]          inta_n;
   logic [N_SRC-1:0]    isr;

   int checks = 0, fails = 0;
   logic [1:0] strobe_seen;

   always #2 clk = ~clk;   // 250 MHz

   localparam logic [2:0] PR [N_SRC] = '{3'd5, 3'd3, 3'd3, 3'd7, 3'd1, 3'd2, 3'd2,
                                         3'd4, 3'd0, 3'd6, 3'd0};
   always_comb for (int i = 0; i < N_SRC; i++) cfg_prio[i*PW +: PW] = PR[i];

   // {ext[4:0], int[3:0], expected irq, expected type}
   localparam int NV = 7;
   localparam logic [17:0] VEC [NV] = '{
      {5'b00001, 4'b0000, 1'b1, 8'd32},
      {5'b00110, 4'b0000, 1'b1, 8'd33},
      {5'b00011, 4'b0001, 1'b1, 8'd33},
      {5'b00000, 4'b0101, 1'b1, 8'd39},
      {5'b10000, 4'b0100, 1'b1, 8'd36},
      {5'b00000, 4'b1001, 1'b1, 8'd42},
      {5'b00000, 4'b0000, 1'b0, 8'd0 }};

   prio_irq_ctrl #(.N_INT(N_INT), .PW(PW), .VEC_BASE(8'd32)) dut (
      .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .int_req(int_req),
      .cfg_level(cfg_level), .cfg_mask(cfg_mask), .cfg_prio(cfg_prio),
      .cfg_cascade(cfg_cascade), .cfg_sfnm(cfg_sfnm), .cfg_slave(cfg_slave),
      .dma_ext_sync(dma_ext_sync), .ien_set(ien_set), .ack(ack), .eoi(eoi),
      .irq(irq), .irq_type(irq_type), .inta_n(inta_n), .ien(ien), .isr(isr));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk); #1;
   endtask

   task automatic pulse_ack();
      @(negedge clk); ack = 1'b1; #1; strobe_seen = inta_n;
      @(posedge clk); @(negedge clk); ack = 1'b0; #1;
   endtask
   task automatic pulse_ien();
      @(negedge clk); ien_set = 1'b1;
      @(posedge clk); @(negedge clk); ien_set = 1'b0; #1;
   endtask
   task automatic pulse_eoi();
      @(negedge clk); eoi = 1'b1;
      @(posedge clk); @(negedge clk); eoi = 1'b0; #1;
   endtask

   initial begin
      #(200000 * 4);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk); #1;
      chk("R1 irq in reset", irq, 0);
      chk("R1 ien in reset", ien, 0);
      chk("R1 isr in reset", int'(isr), 0);
      chk("R1 inta_n in reset", int'(inta_n), 3);
      @(negedge clk); rst_n = 1'b1; step();
      chk("R1 ien after reset", ien, 0);
      chk("R1 isr after reset", int'(isr), 0);

      pulse_ien();
      chk("R7 ien set", ien, 1);

      // R2 arbitration table
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         ext_req[4:0] = VEC[v][17:13];
         int_req      = VEC[v][12:9];
         #1;
         chk($sformatf("R2 irq vec %0d", v), irq, int'(VEC[v][8]));
         if (VEC[v][8]) chk($sformatf("R2 type vec %0d", v), irq_type, int'(VEC[v][7:0]));
      end

      // R7 / R6 / R8 / R9 nesting
      @(negedge clk); ext_req[4] = 1'b1; #1;
      chk("R2 src4 type", irq_type, 36);
      pulse_ack();
      chk("R7 ack clears ien", ien, 0);
      chk("R7 irq low after ack", irq, 0);
      chk("R6 isr bit4 set", int'(isr), 16);
      pulse_ien();
      chk("R6 self blocked", irq, 0);
      @(negedge clk); ext_req[1] = 1'b1; #1;
      chk("R8 weaker blocked", irq, 0);
      @(negedge clk); int_req[1] = 1'b1; #1;
      chk("R8 stronger irq", irq, 1);
      chk("R8 stronger type", irq_type, 40);
      pulse_ack();
      chk("R6 isr nest", int'(isr), 'h110);
      pulse_eoi();
      chk("R9 eoi clears src8", int'(isr), 16);
      pulse_eoi();
      chk("R9 eoi clears src4", int'(isr), 0);
      chk("R7 irq held by ien", irq, 0);
      pulse_ien();
      chk("R7 irq after ien_set", irq, 1);
      chk("R2 type src8", irq_type, 40);
      @(negedge clk); ext_req = '0; int_req = '0; #1;
      chk("R2 idle", irq, 0);

      // R11 mask
      @(negedge clk); cfg_mask[8] = 1'b1; int_req[1] = 1'b1; #1;
      chk("R11 masked", irq, 0);
      @(negedge clk); cfg_mask[8] = 1'b0; #1;
      chk("R11 unmasked", irq, 1);
      @(negedge clk); int_req = '0; #1;

      // R3 edge latch
      @(negedge clk); cfg_level[0] = 1'b0; ext_req[0] = 1'b1;
      step(); ext_req[0] = 1'b0; #1;
      chk("R3 edge latched", irq, 1);
      chk("R3 edge type", irq_type, 32);
      pulse_ack(); pulse_ien(); pulse_eoi();
      chk("R3 edge cleared by ack", irq, 0);
      chk("R3 isr empty", int'(isr), 0);
      @(negedge clk); cfg_level[0] = 1'b1; #1;

      // R6 fully nested
      @(negedge clk); cfg_sfnm[0] = 1'b1; ext_req[0] = 1'b1; #1;
      pulse_ack(); pulse_ien();
      chk("R6 sfnm re-request", irq, 1);
      chk("R6 sfnm type", irq_type, 32);
      pulse_eoi();
      @(negedge clk); ext_req[0] = 1'b0; cfg_sfnm[0] = 1'b0; #1;

      // R4 DMA ownership and edge-only
      @(negedge clk); dma_ext_sync[0] = 1'b1; ext_req[5] = 1'b1;
      step(); ext_req[5] = 1'b0; step();
      chk("R4 dma owns pin5", irq, 0);
      @(negedge clk); dma_ext_sync[0] = 1'b0; ext_req[5] = 1'b1; step();
      chk("R4 pin5 edge", irq, 1);
      chk("R4 pin5 type", irq_type, 37);
      pulse_ack(); pulse_ien(); pulse_eoi();
      chk("R4 held pin5 no rerequest", irq, 0);
      @(negedge clk); ext_req[5] = 1'b0; #1;

      // R10 slave
      @(negedge clk); cfg_slave = 1'b1; ext_req[4] = 1'b1; ext_req[6] = 1'b1; step();
      chk("R10 slave blocks pins", irq, 0);
      @(negedge clk); ext_req[6] = 1'b0; ext_req[4] = 1'b0; step();
      @(negedge clk); cfg_slave = 1'b0; #1;
      chk("R10 edge not kept", irq, 0);

      // R5 cascade
      @(negedge clk); cfg_cascade[0] = 1'b1; ext_req[2] = 1'b1; #1;
      chk("R5 pin2 ignored", irq, 0);
      chk("R5 strobes idle", int'(inta_n), 3);
      @(negedge clk); ext_req[0] = 1'b1; #1;
      chk("R5 src0 type", irq_type, 32);
      pulse_ack();
      chk("R5 strobe0 low", int'(strobe_seen), 2);
      chk("R5 strobe released", int'(inta_n), 3);
      pulse_eoi();
      @(negedge clk); ext_req = '0; cfg_cascade = '0; #1;

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule